// File: doc/BRIEF.md
# Folded Half-Rate FIR Filter

This block is a 21-tap linear-phase filter that halves the sample rate. Signed 21-bit samples arrive with a valid strobe. Each accepted sample enters a delay line. On every second accepted sample, the block copies the delay line and starts an eleven-step multiply-accumulate pass. Because the impulse response is mirror-symmetric, each step first adds the two samples that share a coefficient and then multiplies once. Only eleven coefficients are stored. The sum is rounded back to 21 bits, saturated, and presented with a one-clock valid pulse.

Coefficients are signed 16-bit values with 15 fraction bits. There are two independent banks of them. A write port with address, data, strobe and page bit loads either bank at any time. A bank-select input chooses which bank the datapath reads. The select is captured only when a pass starts, so a result never mixes the two banks. A typical use loads one bank while the filter runs from the other, then flips the select.

Top module: `fir_fold_dec2`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_data` is 0 until the first result.
- R2: `out_valid` pulses high for exactly one clock for every second accepted sample, counting from reset. Accepted samples 2, 4, 6 and so on each produce one result.
- R3: A result equals sum over k=0..20 of h[k]*x[k], where x[0] is the sample that completed the pair and x[k] is the sample accepted k samples earlier (zero before reset). It is registered on the 11th rising edge after the edge that accepted x[0].
- R4: `bank_sel` is sampled on the edge that accepts the pair-completing sample (0 = bank 0, 1 = bank 1). Changes to `bank_sel` while a pass runs do not affect that result.
- R5: A write with `cfg_we`=1 stores `cfg_data` in bank `cfg_page` at coefficient index `cfg_addr`. Index k (0..10) sets h[k] and h[20-k]. Index 10 is the centre tap and is used once.
- R6: Writes to indices 11..15 change no coefficient.
- R7: If the rounded sum exceeds the signed 21-bit range, the output clamps to 1048575 or -1048576.
- R8: Rounding adds 2^14 to the full-precision sum and then shifts it arithmetically right by 15 bits. Halves therefore round toward plus infinity.
- R9: Cycles with `in_valid`=0 leave the delay line and the pairing phase unchanged, whatever `in_data` holds.
- R10: A write to one bank leaves every coefficient of the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 21 | Signed input sample |
| bank_sel | input | 1 | Coefficient bank used by the datapath |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_page | input | 1 | Bank addressed by a write |
| cfg_addr | input | 4 | Coefficient index for a write |
| cfg_data | input | 16 | Signed coefficient value |
| out_valid | output | 1 | One-clock result strobe |
| out_data | output | 21 | Signed rounded, saturated result |

## Verification
The assertions assume that a pair-completing sample never arrives while a pass is still running other than on its final step. This means accepted samples must be at least six clocks apart. The bench's push task always leaves at least that gap. It waits five idle clocks after an odd sample and twelve clocks after an even one. It also toggles `bank_sel` in the middle of each pass and fills `in_data` with noise while `in_valid` is low. This exercises both the bank-latching rule and the rule that idle cycles are ignored, without leaving the assumed input timing.

// File: rtl/fir_fold_dec2.sv
module fir_fold_dec2 #(
  parameter int DW    = 21,
  parameter int CW    = 16,
  parameter int NTAP  = 21,
  parameter int SHIFT = 15,
  parameter int AW    = $clog2((NTAP + 1) / 2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic                 bank_sel,
  input  logic                 cfg_we,
  input  logic                 cfg_page,
  input  logic [AW-1:0]        cfg_addr,
  input  logic signed [CW-1:0] cfg_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  localparam int NU   = (NTAP + 1) / 2;
  localparam int CTR  = NU - 1;
  localparam int IW   = $clog2(NTAP);
  localparam int PW   = DW + 1;
  localparam int ACCW = DW + 1 + CW + AW;
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1) << (SHIFT - 1);

  logic signed [DW-1:0] dline [NTAP];
  logic signed [DW-1:0] snap  [NTAP];
  logic signed [CW-1:0] coef  [2][NU];
  logic                 phase, busy, bsel_q;
  logic [AW-1:0]        idx;
  logic signed [ACCW-1:0] acc;

  wire start = in_valid && phase;
  wire last  = (idx == AW'(CTR));
  wire [IW-1:0] fwd = IW'(idx);
  wire [IW-1:0] mir = IW'(NTAP - 1) - IW'(idx);

  logic signed [PW-1:0]      pre;
  logic signed [PW+CW-1:0]   prod;
  logic signed [ACCW-1:0]    acc_nxt, rnd, sh;
  logic signed [DW-1:0]      sat;

  always_comb begin
    if (last) pre = {snap[fwd][DW-1], snap[fwd]};
    else      pre = {snap[fwd][DW-1], snap[fwd]} + {snap[mir][DW-1], snap[mir]};
    prod    = pre * coef[bsel_q][idx];
    acc_nxt = acc + ACCW'(prod);
    rnd     = acc_nxt + HALF;
    sh      = rnd >>> SHIFT;
    if (!(&sh[ACCW-1:DW-1]) && (|sh[ACCW-1:DW-1]))
      sat = sh[ACCW-1] ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
    else
      sat = sh[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAP; i++) begin
        dline[i] <= '0;
        snap[i]  <= '0;
      end
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NU; i++) coef[b][i] <= '0;
      phase     <= 1'b0;
      busy      <= 1'b0;
      bsel_q    <= 1'b0;
      idx       <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (cfg_we && ({1'b0, cfg_addr} < (AW+1)'(NU)))
        coef[cfg_page][cfg_addr] <= cfg_data;
      if (in_valid) begin
        dline[0] <= in_data;
        for (int i = 1; i < NTAP; i++) dline[i] <= dline[i-1];
        phase <= ~phase;
      end
      if (busy) begin
        acc <= acc_nxt;
        idx <= idx + 1'b1;
        if (last) begin
          busy      <= 1'b0;
          out_valid <= 1'b1;
          out_data  <= sat;
        end
      end
      if (start) begin
        snap[0] <= in_data;
        for (int i = 1; i < NTAP; i++) snap[i] <= dline[i-1];
        busy   <= 1'b1;
        idx    <= '0;
        acc    <= '0;
        bsel_q <= bank_sel;
      end
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (!busy || last));
  assert_out_after_mac_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(busy));
  assert_mac_ends_in_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid);
  assert_bank_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(start)) |-> $stable(bsel_q));
endmodule

// File: tb/sim_fir_fold_dec2.sv
module sim_fir_fold_dec2;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, bank_sel = 1'b0;
  logic signed [20:0] in_data = '0;
  logic cfg_we = 1'b0, cfg_page = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic signed [15:0] cfg_data = '0;
  logic out_valid;
  logic signed [20:0] out_data;

  int total = 0, bad = 0;
  longint hist [21];
  longint cm [2][11];
  bit ph = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_fold_dec2 u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .bank_sel(bank_sel), .cfg_we(cfg_we), .cfg_page(cfg_page),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .out_valid(out_valid), .out_data(out_data));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint model_out(input int b);
    longint acc = 0;
    for (int k = 0; k < 21; k++) acc += hist[k] * cm[b][(k < 11) ? k : 20 - k];
    acc = (acc + 64'sd16384) >>> 15;
    if (acc > 1048575) acc = 1048575;
    if (acc < -1048576) acc = -1048576;
    return acc;
  endfunction

  task automatic wr(input bit page, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_page = page; cfg_addr = 4'(addr); cfg_data = 16'(data);
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_data = 16'($urandom);
    if (addr < 11) cm[page][addr] = longint'(signed'(16'(data)));
  endtask

  task automatic push(input logic signed [20:0] s, input bit b, input string tag);
    longint exp;
    bit early = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; in_data = s; bank_sel = b;
    @(posedge clk); #1;
    in_valid = 1'b0; in_data = 21'($urandom);
    for (int k = 20; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = longint'(s);
    if (ph) begin
      exp = model_out(b);
      for (int k = 1; k <= 11; k++) begin
        @(posedge clk); #1;
        if (k == 3) bank_sel = ~b;
        if (k < 11 && out_valid) early = 1'b1;
      end
      check(!early, "R3 latency (early valid)", early, 0);
      check(out_valid === 1'b1, "R2 valid on second sample", out_valid, 1);
      check(longint'(out_data) == exp, tag, out_data, exp);
      @(posedge clk); #1;
      check(out_valid === 1'b0, "R2 single-cycle pulse", out_valid, 0);
    end else begin
      repeat (5) begin
        @(posedge clk); #1;
        if (out_valid) early = 1'b1;
      end
      check(!early, "R2 no result on odd sample", early, 0);
    end
    ph = ~ph;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    for (int k = 0; k < 21; k++) hist[k] = 0;
    for (int b = 0; b < 2; b++) for (int i = 0; i < 11; i++) cm[b][i] = 0;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid === 1'b0, "R1 valid low in reset", out_valid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check(out_valid === 1'b0 && out_data === '0, "R1 idle after reset", out_data, 0);

    for (int i = 0; i < 11; i++) wr(1'b0, i, int'($urandom % 65536) - 32768);
    for (int i = 0; i < 11; i++) wr(1'b1, i, int'($urandom % 65536) - 32768);
    for (int n = 0; n < 40; n++)
      push(21'($urandom), 1'($urandom), "R3 R4 R5 R10 random result");

    for (int a = 11; a < 16; a++) wr(1'($urandom), a, int'($urandom % 65536) - 32768);
    for (int n = 0; n < 10; n++) push(21'($urandom), 1'($urandom), "R6 result after ignored writes");

    for (int i = 0; i < 11; i++) wr(1'b1, i, 32767);
    for (int n = 0; n < 22; n++) push(21'sd1048575, 1'b1, "R7 positive clamp");
    for (int n = 0; n < 22; n++) push(-21'sd1048576, 1'b1, "R7 negative clamp");

    for (int i = 0; i < 10; i++) wr(1'b0, i, 0);
    wr(1'b0, 10, 1);
    for (int n = 0; n < 30; n++) begin
      int pick = int'($urandom % 5);
      logic signed [20:0] v;
      case (pick)
        0: v = 21'sd16384;
        1: v = 21'sd16383;
        2: v = -21'sd16384;
        3: v = -21'sd16385;
        default: v = 21'sd49152;
      endcase
      push(v, 1'b0, "R8 half rounding");
    end

    for (int i = 0; i < 11; i++) wr(1'b0, i, int'($urandom % 65536) - 32768);
    wr(1'b1, 0, 12345);
    for (int n = 0; n < 60; n++) begin
      push(21'($urandom), 1'($urandom), "R9 R10 random after mixed writes");
      repeat (int'($urandom % 4)) begin
        @(negedge clk); in_data = 21'($urandom);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule